// File: doc/BRIEF.md
# Hit-Driven Multichannel Digitisation Sequencer

This block is the digital controller of a multichannel front-end chip whose channels all share a single slow 12-bit converter. Each channel has two inputs. The first is a discriminator strobe, which marks the arrival of a pulse. The second is a peak-ready level, which rises once the shaped pulse has settled on its hold capacitor. When a strobe arrives, the block copies the running global timestamp into that channel's slot on the same clock edge. The time tag therefore records when the hit occurred, not when its conversion later happens.

Channels that hold a sample and report their peak ready compete for the converter. A round-robin arbiter grants one of them. The block then starts a conversion for that channel and waits for the converter to finish. It packs the result with the channel number, the stored timestamp and a pileup flag into one record and pushes the record into an on-chip buffer. A serial transmitter drains the buffer one record at a time, most significant bit first.

Quiet channels never reach the converter and never produce a record. The serial output is a valid/ready stream. A bit moves only in a cycle where both `ser_valid` and `ser_ready` are high, and while `ser_ready` is low the transmitter holds its current bit. If the buffer fills, the arbiter stops granting. Channels that are still waiting keep their held state and their timestamp until space appears.

Top module: `hit_digitiser`

## Requirements
- R1: After reset, `adc_start` and `ser_valid` are low and no record is produced until a channel is hit.
- R2: A channel that is not holding a sample and sees `hit` high at a clock edge stores the `ts_now` value present at that same edge. That stored value is the timestamp carried by its record.
- R3: Only channels that were hit produce records. Each accepted hit yields exactly one record.
- R4: A held channel is converted only while its `peak_rdy` input is high. A conversion is requested by a single-cycle `adc_start` pulse, and `adc_chan` names the channel being converted.
- R5: Among held channels with `peak_rdy` high, the grant goes to the first one found searching upward (with wraparound) from the channel after the one served last. After reset, the search begins at channel 0.
- R6: A `hit` on a channel that already holds a sample sets that channel's pileup flag. It keeps the first timestamp and adds no extra record.
- R7: A record is 67 bits wide. Bits [66:61] hold the channel, [60:49] hold the ADC value, [48:1] hold the timestamp and bit [0] holds the pileup flag.
- R8: The serial stream sends each record MSB first. A bit advances only when `ser_valid` and `ser_ready` are both high. While stalled, `ser_valid`, `ser_data` and `ser_last` hold their values. `ser_last` marks the record's final bit.
- R9: While the record buffer is full, no new conversion is started and no record is ever overwritten. Waiting channels are converted once space frees. With an 8-entry buffer and a stalled serial sink, exactly 9 conversions complete: 8 records in the buffer and 1 in the transmitter.
- R10: The ADC value in a record is the `adc_data` present on the cycle `adc_done` is high after that channel's `adc_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_now | input | 48 | Running global timestamp |
| hit | input | 64 | Per-channel discriminator strobe |
| peak_rdy | input | 64 | Per-channel peak-held indication |
| adc_start | output | 1 | One-cycle conversion request |
| adc_chan | output | 6 | Channel routed to the converter |
| adc_done | input | 1 | Converter result valid |
| adc_data | input | 12 | Converter result |
| ser_valid | output | 1 | Record bit valid (frame active) |
| ser_ready | input | 1 | Sink accepts the current bit |
| ser_data | output | 1 | Current record bit |
| ser_last | output | 1 | Current bit is the record's final bit |

## Verification
The bench drops a hit on a channel whose peak is not yet ready. A controller that ignores the ready level would start a conversion early, and that stray `adc_start` is counted. A second hit is then sent to a held channel. A wrong design would overwrite the first timestamp or emit a second record, and either would show in the decoded record. Several simultaneous hits, placed on both sides of the last-served channel, expose an arbiter that searches from channel 0 instead of rotating. A stalled sink with twelve waiting channels exposes both a buffer that overwrites and an arbiter that fails to resume once space frees: the first would lose records, the second would leave channels unserved.

// File: rtl/hd_pkg.sv
package hd_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_START = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/hd_chan_bank.sv
module hd_chan_bank #(
  parameter int NCH   = 64,
  parameter int TS_W  = 48,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   hit,
  input  logic [TS_W-1:0]  ts_now,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [NCH-1:0]   held,
  output logic [TS_W-1:0]  rd_ts,
  output logic             rd_pile
);
  logic [TS_W-1:0] ts_q [NCH];
  logic [NCH-1:0]  pile;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic            held_r;
    logic            pile_r;
    logic [TS_W-1:0] ts_r;
    logic            clr_me;

    assign clr_me = clr_en && (clr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held_r <= 1'b0;
        pile_r <= 1'b0;
        ts_r   <= '0;
      end else if (clr_me) begin
        // slot released; a hit landing in the same cycle starts a fresh sample
        held_r <= hit[g];
        pile_r <= 1'b0;
        if (hit[g]) ts_r <= ts_now;
      end else if (hit[g]) begin
        if (held_r) begin
          pile_r <= 1'b1;
        end else begin
          held_r <= 1'b1;
          ts_r   <= ts_now;
        end
      end
    end

    assign held[g] = held_r;
    assign pile[g] = pile_r;
    assign ts_q[g] = ts_r;
  end

  assign rd_ts   = ts_q[rd_idx];
  assign rd_pile = pile[rd_idx];
endmodule

// File: rtl/hd_rr_arb.sv
module hd_rr_arb #(
  parameter int NCH   = 64,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]   req,
  input  logic [IDX_W-1:0] last,
  output logic             gnt_vld,
  output logic [IDX_W-1:0] gnt_idx
);
  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    // walk from the farthest offset down so the nearest requester wins
    for (int k = NCH; k >= 1; k--) begin
      int unsigned j;
      j = (int'(last) + k) % NCH;
      if (req[j]) begin
        gnt_vld = 1'b1;
        gnt_idx = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/hd_rec_fifo.sv
module hd_rec_fifo #(
  parameter int W     = 67,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= din;
  end
endmodule

// File: rtl/hd_ser_tx.sv
module hd_ser_tx #(
  parameter int W   = 67,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  output logic         in_pop,
  output logic         ser_valid,
  input  logic         ser_ready,
  output logic         ser_data,
  output logic         ser_last
);
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          busy;

  assign in_pop    = !busy && in_vld;
  assign ser_valid = busy;
  assign ser_data  = sh[W-1];
  assign ser_last  = busy && (cnt == CW'(W-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '0;
      cnt  <= '0;
    end else if (in_pop) begin
      busy <= 1'b1;
      sh   <= in_data;
      cnt  <= '0;
    end else if (busy && ser_ready) begin
      if (cnt == CW'(W-1)) begin
        busy <= 1'b0;
      end else begin
        sh  <= {sh[W-2:0], 1'b0};
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hit_digitiser.sv
module hit_digitiser #(
  parameter int NCH    = 64,
  parameter int ADC_W  = 12,
  parameter int TS_W   = 48,
  parameter int FDEPTH = 8,
  localparam int IDX_W = $clog2(NCH),
  localparam int REC_W = IDX_W + ADC_W + TS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  ts_now,
  input  logic [NCH-1:0]   hit,
  input  logic [NCH-1:0]   peak_rdy,
  output logic             adc_start,
  output logic [IDX_W-1:0] adc_chan,
  input  logic             adc_done,
  input  logic [ADC_W-1:0] adc_data,
  output logic             ser_valid,
  input  logic             ser_ready,
  output logic             ser_data,
  output logic             ser_last
);
  import hd_pkg::*;

  seq_st_e          st;
  logic [IDX_W-1:0] cur_idx, last_idx;
  logic [NCH-1:0]   held_w;
  logic [TS_W-1:0]  cur_ts;
  logic             cur_pile;
  logic             gnt_vld;
  logic [IDX_W-1:0] gnt_idx;
  logic             fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [REC_W-1:0] fifo_din, fifo_dout;

  hd_chan_bank #(.NCH(NCH), .TS_W(TS_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .hit(hit), .ts_now(ts_now),
    .clr_en(fifo_push), .clr_idx(cur_idx), .rd_idx(cur_idx),
    .held(held_w), .rd_ts(cur_ts), .rd_pile(cur_pile)
  );

  hd_rr_arb #(.NCH(NCH), .IDX_W(IDX_W)) u_arb (
    .req(held_w & peak_rdy), .last(last_idx),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      cur_idx  <= '0;
      last_idx <= IDX_W'(NCH-1);
    end else begin
      unique case (st)
        SQ_IDLE: if (gnt_vld && !fifo_full) begin
          cur_idx <= gnt_idx;
          st      <= SQ_START;
        end
        SQ_START: st <= SQ_WAIT;
        SQ_WAIT: if (adc_done) begin
          last_idx <= cur_idx;
          st       <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign adc_start = (st == SQ_START);
  assign adc_chan  = cur_idx;
  assign fifo_push = (st == SQ_WAIT) && adc_done;
  assign fifo_din  = {cur_idx, adc_data, cur_ts, cur_pile};

  hd_rec_fifo #(.W(REC_W), .DEPTH(FDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(fifo_din),
    .pop(fifo_pop), .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full)
  );

  hd_ser_tx #(.W(REC_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .in_vld(!fifo_empty), .in_data(fifo_dout),
    .in_pop(fifo_pop), .ser_valid(ser_valid), .ser_ready(ser_ready),
    .ser_data(ser_data), .ser_last(ser_last)
  );
endmodule

// File: rtl/hd_chk.sv
module hd_chk #(
  parameter int NCH   = 64,
  parameter int IDX_W = $clog2(NCH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adc_start,
  input logic [IDX_W-1:0] adc_chan,
  input logic [NCH-1:0]   held_w,
  input logic             fifo_full,
  input logic             fifo_push,
  input logic             ser_valid,
  input logic             ser_ready,
  input logic             ser_data,
  input logic             ser_last
);
  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R4
  start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> held_w[adc_chan]);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_push);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && !ser_ready) |=> (ser_valid && $stable(ser_data) && $stable(ser_last)));

  // R8
  last_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_last |-> ser_valid);
endmodule

bind hit_digitiser hd_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_chan(adc_chan),
  .held_w(held_w), .fifo_full(fifo_full), .fifo_push(fifo_push),
  .ser_valid(ser_valid), .ser_ready(ser_ready), .ser_data(ser_data),
  .ser_last(ser_last)
);

// File: tb/hit_digitiser_test.sv
module hit_digitiser_test;
  localparam int NCH = 64, ADC_W = 12, TS_W = 48, IDX_W = 6, FDEPTH = 8;
  localparam int REC_W = IDX_W + ADC_W + TS_W + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TS_W-1:0]  ts_now = 48'h0001_0000_0000;
  logic [NCH-1:0]   hit = '0, peak_rdy = '1;
  logic             adc_start, adc_done = 1'b0;
  logic [IDX_W-1:0] adc_chan;
  logic [ADC_W-1:0] adc_data = '0;
  logic             ser_valid, ser_ready = 1'b1, ser_data, ser_last;

  int checks = 0, fails = 0, starts = 0;
  logic [REC_W-1:0] rxq[$];
  logic [REC_W-1:0] rx_sh = '0;
  logic [2:0]       acnt = '0;
  logic [IDX_W-1:0] ach = '0;

  always #2.5 clk = ~clk;

  hit_digitiser uut (
    .clk(clk), .rst_n(rst_n), .ts_now(ts_now), .hit(hit), .peak_rdy(peak_rdy),
    .adc_start(adc_start), .adc_chan(adc_chan), .adc_done(adc_done),
    .adc_data(adc_data), .ser_valid(ser_valid), .ser_ready(ser_ready),
    .ser_data(ser_data), .ser_last(ser_last)
  );

  function automatic logic [ADC_W-1:0] fval(input logic [IDX_W-1:0] ch);
    return ADC_W'(int'(ch) * 67 + 291);
  endfunction

  always @(posedge clk) ts_now <= ts_now + 1'b1;

  // converter model: result three cycles after the start pulse
  always @(posedge clk) begin
    adc_done <= 1'b0;
    if (rst_n && adc_start) begin
      acnt <= 3'd3;
      ach  <= adc_chan;
      starts++;
    end else if (acnt != 0) begin
      acnt <= acnt - 1'b1;
      if (acnt == 3'd1) begin
        adc_done <= 1'b1;
        adc_data <= fval(ach);
      end
    end
  end

  // serial sink
  always @(posedge clk) begin
    if (rst_n && ser_valid && ser_ready) begin
      if (ser_last) rxq.push_back({rx_sh[REC_W-2:0], ser_data});
      rx_sh <= {rx_sh[REC_W-2:0], ser_data};
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_recs(input int n);
    int guard = 0;
    while (rxq.size() < n && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic check_rec(input string req, input logic [IDX_W-1:0] ch,
                           input logic [TS_W-1:0] ts, input bit pile);
    logic [REC_W-1:0] r;
    if (rxq.size() == 0) begin
      chk(1'b0, req, 0, 1);
      return;
    end
    r = rxq.pop_front();
    // R7 field positions: chan [66:61], adc [60:49], ts [48:1], pileup [0]
    chk(r[66:61] == ch, {req, " R7 chan"}, 64'(r[66:61]), 64'(ch));
    chk(r[60:49] == fval(ch), {req, " R10 adc"}, 64'(r[60:49]), 64'(fval(ch)));
    chk(r[48:1] == ts, {req, " R2 ts"}, 64'(r[48:1]), 64'(ts));
    chk(r[0] == pile, {req, " R6 pileup"}, 64'(r[0]), 64'(pile));
  endtask

  task automatic pulse_hits(input logic [NCH-1:0] v, output logic [TS_W-1:0] t);
    @(negedge clk);
    hit = v;
    t = ts_now;
    @(negedge clk);
    hit = '0;
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk(adc_start == 1'b0, "R1 adc_start", 64'(adc_start), 0);
    chk(ser_valid == 1'b0, "R1 ser_valid", 64'(ser_valid), 0);
    chk(rxq.size() == 0, "R1 no record", 64'(rxq.size()), 0);
  endtask

  task automatic t_single();
    logic [TS_W-1:0] t;
    pulse_hits(64'(1) << 5, t);
    wait_recs(1);
    check_rec("R2 single ch5", 6'd5, t, 1'b0);
  endtask

  task automatic t_peak_gate();
    logic [TS_W-1:0] t;
    int s0 = starts;
    peak_rdy[3] = 1'b0;
    pulse_hits(64'(1) << 3, t);
    repeat (60) @(negedge clk);
    chk(starts == s0, "R4 no start before peak", 64'(starts - s0), 0);
    chk(rxq.size() == 0, "R3 no record yet", 64'(rxq.size()), 0);
    peak_rdy[3] = 1'b1;
    wait_recs(1);
    check_rec("R4 gated ch3", 6'd3, t, 1'b0);
    repeat (100) @(negedge clk);
    chk(rxq.size() == 0 && starts == s0 + 1, "R3 one record per hit", 64'(starts - s0), 1);
  endtask

  task automatic t_round_robin();
    logic [TS_W-1:0] t;
    pulse_hits((64'(1) << 30) | (64'(1) << 10) | (64'(1) << 20), t);
    wait_recs(3);
    check_rec("R5 rr first", 6'd10, t, 1'b0);
    check_rec("R5 rr second", 6'd20, t, 1'b0);
    check_rec("R5 rr third", 6'd30, t, 1'b0);
    pulse_hits((64'(1) << 2) | (64'(1) << 40), t);
    wait_recs(2);
    check_rec("R5 wrap first", 6'd40, t, 1'b0);
    check_rec("R5 wrap second", 6'd2, t, 1'b0);
  endtask

  task automatic t_pileup();
    logic [TS_W-1:0] t1, t2;
    int s0 = starts;
    peak_rdy[7] = 1'b0;
    pulse_hits(64'(1) << 7, t1);
    repeat (4) @(negedge clk);
    pulse_hits(64'(1) << 7, t2);
    repeat (20) @(negedge clk);
    chk(starts == s0, "R6 held waits", 64'(starts - s0), 0);
    peak_rdy[7] = 1'b1;
    wait_recs(1);
    check_rec("R6 pileup ch7", 6'd7, t1, 1'b1);
    repeat (150) @(negedge clk);
    chk(rxq.size() == 0, "R6 no second record", 64'(rxq.size()), 0);
    chk(starts == s0 + 1, "R6 one conversion", 64'(starts - s0), 1);
  endtask

  task automatic t_full();
    logic [TS_W-1:0] t;
    logic d0;
    int s0;
    @(negedge clk);
    ser_ready = 1'b0;
    s0 = starts;
    pulse_hits(64'hFFF << 50, t);
    repeat (300) @(negedge clk);
    chk(starts - s0 == FDEPTH + 1, "R9 stalled conversions", 64'(starts - s0), 64'(FDEPTH + 1));
    chk(ser_valid == 1'b1, "R8 valid while stalled", 64'(ser_valid), 1);
    d0 = ser_data;
    @(negedge clk);
    chk(ser_data == d0, "R8 data held while stalled", 64'(ser_data), 64'(d0));
    ser_ready = 1'b1;
    wait_recs(12);
    chk(starts - s0 == 12, "R9 all converted", 64'(starts - s0), 12);
    for (int i = 0; i < 12; i++) check_rec("R9 drained", 6'(50 + i), t, 1'b0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_peak_gate();
    t_round_robin();
    t_pileup();
    t_full();
    summary();
    $finish;
  end
endmodule